// File: doc/BRIEF.md
# Watchdog Key-Protected Register Interface

This block is the bus-facing register file of a watchdog whose down-counter runs on a separate, slow, free-running clock. The bus side writes 16-bit codes to a key location. One code starts the watchdog, one refreshes it, and one opens the configuration registers for writing. Any other code, the refresh code included, closes them again. The configuration registers are the clock divider select, the reload value and the window limit.

Each accepted configuration write is held on the bus side. It is passed to the slow domain with a toggle request/acknowledge handshake, and each direction of that handshake goes through a synchronizer chain. While a value is in flight, its busy flag in the status register stays set, and further writes to that register are dropped. The start and refresh codes reach the slow domain as single-cycle pulses there. The slow-domain copies of the configuration drive the counter, and the same copies are what the bus reads back.

Top module: `wdk_regif`

## Requirements
- R1: A bus write of 0x5555 to offset 0x00 unlocks the configuration registers, so that a later write to offset 0x04 (divider select, bits 2:0), 0x08 (reload, bits 11:0) or 0x10 (window, bits 11:0) is accepted.
- R2: A bus write to offset 0x00 of any value other than 0x5555, 0xAAAA and 0xCCCC included, locks the configuration registers. While they are locked, a configuration write changes neither the stored value nor the status flags.
- R3: A write of 0xCCCC to offset 0x00 yields exactly one start pulse on the slow clock, and a write of 0xAAAA yields exactly one refresh pulse. Any other key value yields neither pulse.
- R4: Offset 0x00 reads as zero at all times, and so does any offset outside 0x00, 0x04, 0x08, 0x0C and 0x10.
- R5: Offset 0x0C reads the busy flags: bit 0 for the divider, bit 1 for the reload and bit 2 for the window. All higher bits read as zero.
- R6: An accepted configuration write sets its busy flag in the bus cycle after the write edge. The flag clears within five slow-clock periods plus two bus cycles.
- R7: A write to a configuration register whose busy flag is set is ignored. The value that is already in flight is the one that lands.
- R8: Reads of offsets 0x04, 0x08 and 0x10 return the slow-domain copy, zero-extended. Once the busy flag clears, the copy and the matching slow-domain output equal the written value.
- R9: After reset the divider select is 0, reload and window are 0xFFF, the status reads 0 and the registers are locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | 5 | Write byte offset |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 5 | Read byte offset |
| bus_rdata | output | 16 | Read data, combinational from bus_raddr |
| slow_clk | input | 1 | Watchdog counter clock |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| start_pulse | output | 1 | One slow-cycle start command |
| feed_pulse | output | 1 | One slow-cycle refresh command |
| div_sel | output | 3 | Divider select, slow domain |
| reload_val | output | 12 | Reload value, slow domain |
| window_val | output | 12 | Window limit, slow domain |

## Verification
The bench checks that the refresh key relocks the registers: a design that treated it as neutral would accept the later window write, and the read-back would show the new value. It also writes a register a second time while its first value is still in flight. A design that took that second write, or that overwrote its holding register, would read back the second value. The bench checks that an unknown key relocks the registers and raises no command pulse, and that two channels busy at once show up as two separate status bits. A design that mixed up the flag bit order, or let one channel's acknowledge clear another's flag, would fail those status reads.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;

   localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DIV = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_RLD = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STS = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;

   localparam logic [DATA_W-1:0] KEY_OPEN  = 16'h5555;
   localparam logic [DATA_W-1:0] KEY_FEED  = 16'hAAAA;
   localparam logic [DATA_W-1:0] KEY_START = 16'hCCCC;

   localparam int N_CHAN = 3;
   localparam int CH_DIV = 0;
   localparam int CH_RLD = 1;
   localparam int CH_WIN = 2;
endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_chk
      $error("wdk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdk_key_decode.sv
module wdk_key_decode
   import wdk_pkg::*;
(
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key,
   output logic              do_start,
   output logic              do_feed,
   output logic              do_open,
   output logic              do_close
);
   always_comb begin
      do_start = key_wr && (key == KEY_START);
      do_feed  = key_wr && (key == KEY_FEED);
      do_open  = key_wr && (key == KEY_OPEN);
      do_close = key_wr && (key != KEY_OPEN);
   end
endmodule

// File: rtl/wdk_cmd_xfer.sv
module wdk_cmd_xfer #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic sclk,
   input  logic srst_n,
   output logic pulse
);
   logic tgl, tgl_s, seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tgl <= 1'b0;
      else if (fire) tgl <= ~tgl;
   end

   wdk_sync #(.STAGES(STAGES)) u_sync (
      .clk(sclk), .rst_n(srst_n), .d(tgl), .q(tgl_s)
   );

   always_ff @(posedge sclk or negedge srst_n) begin
      if (!srst_n) seen <= 1'b0;
      else         seen <= tgl_s;
   end

   assign pulse = tgl_s ^ seen;
endmodule

// File: rtl/wdk_cfg_chan.sv
module wdk_cfg_chan #(
   parameter int          W       = 12,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter int          STAGES  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   output logic         busy,
   input  logic         sclk,
   input  logic         srst_n,
   output logic [W-1:0] sval
);
   logic [W-1:0] hold;
   logic         req_tgl, ack_b;
   logic         req_s, ack_tgl;

   // bus side: capture only when no transfer is outstanding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= RST_VAL;
         req_tgl <= 1'b0;
      end else if (wr_req && !busy) begin
         hold    <= wr_data;
         req_tgl <= ~req_tgl;
      end
   end

   assign busy = req_tgl ^ ack_b;

   wdk_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(sclk), .rst_n(srst_n), .d(req_tgl), .q(req_s)
   );

   // slow side: hold is stable while the request is pending
   always_ff @(posedge sclk or negedge srst_n) begin
      if (!srst_n) begin
         sval    <= RST_VAL;
         ack_tgl <= 1'b0;
      end else if (req_s != ack_tgl) begin
         sval    <= hold;
         ack_tgl <= req_s;
      end
   end

   wdk_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_b)
   );
endmodule

// File: rtl/wdk_regif.sv
module wdk_regif
   import wdk_pkg::*;
#(
   parameter int DIV_W       = 3,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_waddr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              slow_clk,
   input  logic              slow_rst_n,
   output logic              start_pulse,
   output logic              feed_pulse,
   output logic [DIV_W-1:0]  div_sel,
   output logic [CNT_W-1:0]  reload_val,
   output logic [CNT_W-1:0]  window_val
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (DIV_W < 1 || DIV_W > DATA_W) begin : g_div_chk
      $error("wdk_regif: DIV_W out of range");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_cnt_chk
      $error("wdk_regif: CNT_W out of range");
   end

   logic key_wr, do_start, do_feed, do_open, do_close;
   logic unlocked;
   logic [N_CHAN-1:0] busy_vec;
   logic [N_CHAN-1:0] chan_wr;

   assign key_wr = bus_we && (bus_waddr == OFS_KEY);

   wdk_key_decode u_dec (
      .key_wr(key_wr), .key(bus_wdata),
      .do_start(do_start), .do_feed(do_feed),
      .do_open(do_open), .do_close(do_close)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        unlocked <= 1'b0;
      else if (do_open)  unlocked <= 1'b1;
      else if (do_close) unlocked <= 1'b0;
   end

   always_comb begin
      chan_wr         = '0;
      chan_wr[CH_DIV] = bus_we && unlocked && (bus_waddr == OFS_DIV);
      chan_wr[CH_RLD] = bus_we && unlocked && (bus_waddr == OFS_RLD);
      chan_wr[CH_WIN] = bus_we && unlocked && (bus_waddr == OFS_WIN);
   end

   wdk_cfg_chan #(.W(DIV_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_div (
      .clk(clk), .rst_n(rst_n), .wr_req(chan_wr[CH_DIV]),
      .wr_data(bus_wdata[DIV_W-1:0]), .busy(busy_vec[CH_DIV]),
      .sclk(slow_clk), .srst_n(slow_rst_n), .sval(div_sel)
   );

   wdk_cfg_chan #(.W(CNT_W), .RST_VAL(CNT_MAX), .STAGES(SYNC_STAGES)) u_rld (
      .clk(clk), .rst_n(rst_n), .wr_req(chan_wr[CH_RLD]),
      .wr_data(bus_wdata[CNT_W-1:0]), .busy(busy_vec[CH_RLD]),
      .sclk(slow_clk), .srst_n(slow_rst_n), .sval(reload_val)
   );

   wdk_cfg_chan #(.W(CNT_W), .RST_VAL(CNT_MAX), .STAGES(SYNC_STAGES)) u_win (
      .clk(clk), .rst_n(rst_n), .wr_req(chan_wr[CH_WIN]),
      .wr_data(bus_wdata[CNT_W-1:0]), .busy(busy_vec[CH_WIN]),
      .sclk(slow_clk), .srst_n(slow_rst_n), .sval(window_val)
   );

   wdk_cmd_xfer #(.STAGES(SYNC_STAGES)) u_start (
      .clk(clk), .rst_n(rst_n), .fire(do_start),
      .sclk(slow_clk), .srst_n(slow_rst_n), .pulse(start_pulse)
   );

   wdk_cmd_xfer #(.STAGES(SYNC_STAGES)) u_feed (
      .clk(clk), .rst_n(rst_n), .fire(do_feed),
      .sclk(slow_clk), .srst_n(slow_rst_n), .pulse(feed_pulse)
   );

   always_comb begin
      unique case (bus_raddr)
         OFS_DIV: bus_rdata = DATA_W'(div_sel);
         OFS_RLD: bus_rdata = DATA_W'(reload_val);
         OFS_STS: bus_rdata = DATA_W'(busy_vec);
         OFS_WIN: bus_rdata = DATA_W'(window_val);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdk_regif_chk.sv
module wdk_regif_chk
   import wdk_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_waddr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [ADDR_W-1:0] bus_raddr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              unlocked,
   input logic [N_CHAN-1:0] busy_vec
);
   logic key_wr;
   assign key_wr = bus_we && (bus_waddr == OFS_KEY);

   assert_open_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr && (bus_wdata == KEY_OPEN) |=> unlocked);

   assert_close_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr && (bus_wdata != KEY_OPEN) |=> !unlocked);

   assert_locked_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !unlocked && (bus_waddr == OFS_RLD) && !busy_vec[CH_RLD]
      |=> !busy_vec[CH_RLD]);

   assert_accept_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && unlocked && (bus_waddr == OFS_WIN) && !busy_vec[CH_WIN]
      |=> busy_vec[CH_WIN]);

   assert_busy_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_vec[CH_DIV]) |-> $past(bus_we && unlocked && (bus_waddr == OFS_DIV)));

   assert_key_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_raddr == OFS_KEY) |-> (bus_rdata == '0));

   assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_raddr == OFS_STS) |-> (bus_rdata == DATA_W'(busy_vec)));
endmodule

bind wdk_regif wdk_regif_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
   .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
   .unlocked(unlocked), .busy_vec(busy_vec)
);

// File: tb/wdk_regif_bench.sv
module wdk_regif_bench;
   logic        clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_waddr = '0;
   logic [15:0] bus_wdata = '0;
   logic [4:0]  bus_raddr = '0;
   logic [15:0] bus_rdata;
   logic        start_pulse, feed_pulse;
   logic [2:0]  div_sel;
   logic [11:0] reload_val, window_val;

   int total = 0;
   int bad = 0;
   int start_cnt = 0;
   int feed_cnt = 0;

   typedef struct {
      logic [4:0]  addr;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   always #5 clk = ~clk;
   always #21 slow_clk = ~slow_clk;

   wdk_regif u_wdk_regif (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
      .start_pulse(start_pulse), .feed_pulse(feed_pulse),
      .div_sel(div_sel), .reload_val(reload_val), .window_val(window_val)
   );

   always @(negedge slow_clk) begin
      if (start_pulse) start_cnt++;
      if (feed_pulse)  feed_cnt++;
   end

   // monitor: compares read data against the queued expectation
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         rd_item_t it;
         it = sb_q.pop_front();
         total++;
         if (bus_rdata !== it.exp) begin
            bad++;
            $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h",
                     it.tag, it.addr, bus_rdata, it.exp);
         end
      end
   end

   task automatic expect_rd(input logic [4:0] a, input logic [15:0] e, input string tag);
      rd_item_t it;
      @(posedge clk); #1;
      bus_raddr = a;
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic chk(input int got, input int exp, input string tag);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(posedge slow_clk);
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int s0, f0;
      repeat (4) @(posedge slow_clk);
      #1; rst_n = 1'b1; slow_rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R9 reset state, R4 key reads zero
      expect_rd(5'h04, 16'h0000, "R9 divider reset");
      expect_rd(5'h08, 16'h0FFF, "R9 reload reset");
      expect_rd(5'h10, 16'h0FFF, "R9 window reset");
      expect_rd(5'h0C, 16'h0000, "R9 status reset");
      expect_rd(5'h00, 16'h0000, "R4 key reads zero");
      chk(int'(div_sel), 0, "R9 div_sel reset");
      chk(int'(reload_val), 'hFFF, "R9 reload_val reset");

      // R2/R9 locked after reset: write ignored
      wr(5'h08, 16'h0123);
      expect_rd(5'h0C, 16'h0000, "R2 locked write leaves status clear");
      settle();
      expect_rd(5'h08, 16'h0FFF, "R2 locked write ignored");

      // R1 unlock, R6 busy, R7 write while busy ignored
      wr(5'h00, 16'h5555);
      wr(5'h08, 16'h0123);
      expect_rd(5'h0C, 16'h0002, "R6 reload busy set");
      wr(5'h08, 16'h0456);
      settle();
      expect_rd(5'h0C, 16'h0000, "R6 reload busy cleared");
      expect_rd(5'h08, 16'h0123, "R7 busy write ignored");
      chk(int'(reload_val), 'h123, "R8 reload_val output");

      // R5 two flags together, R8 readback
      wr(5'h04, 16'h0005);
      wr(5'h10, 16'h0800);
      expect_rd(5'h0C, 16'h0005, "R5 divider and window bits");
      settle();
      expect_rd(5'h04, 16'h0005, "R8 divider readback");
      expect_rd(5'h10, 16'h0800, "R8 window readback");
      chk(int'(div_sel), 5, "R8 div_sel output");
      chk(int'(window_val), 'h800, "R8 window_val output");

      // R3 refresh pulse, R2 refresh key relocks
      s0 = start_cnt; f0 = feed_cnt;
      wr(5'h00, 16'hAAAA);
      settle();
      chk(feed_cnt - f0, 1, "R3 refresh pulse count");
      chk(start_cnt - s0, 0, "R3 no start on refresh");
      wr(5'h10, 16'h0100);
      settle();
      expect_rd(5'h10, 16'h0800, "R2 refresh key relocks");

      // R3 start pulse
      s0 = start_cnt; f0 = feed_cnt;
      wr(5'h00, 16'hCCCC);
      settle();
      chk(start_cnt - s0, 1, "R3 start pulse count");
      chk(feed_cnt - f0, 0, "R3 no refresh on start");

      // R2 unknown key relocks, R3 no pulses from it
      s0 = start_cnt; f0 = feed_cnt;
      wr(5'h00, 16'h5555);
      wr(5'h00, 16'h1234);
      wr(5'h04, 16'h0002);
      settle();
      expect_rd(5'h04, 16'h0005, "R2 unknown key relocks");
      chk(start_cnt - s0 + feed_cnt - f0, 0, "R3 unknown key no pulse");

      // R4 unmapped and key offset after traffic
      expect_rd(5'h14, 16'h0000, "R4 unmapped reads zero");
      expect_rd(5'h00, 16'h0000, "R4 key still reads zero");

      repeat (3) @(posedge clk);
      summary();
      $finish;
   end
endmodule